// File: doc/BRIEF.md
# SPI Interrupt Status Aggregator

This block is the shared interrupt and test logic that sits beside a group of SPI channels. Each channel reports level-sensitive events (transmit empty, transmit underrun, receive full), and the module adds one receive-overrun event for channel 0 and one wakeup event. Every event sets a sticky bit in an interrupt status register. The status register is masked by an enable register, and a single registered interrupt line goes high whenever a status bit is also enabled. Software acknowledges an event by writing a 1 to its status bit.

A small control set sits next to the status logic: a wakeup-enable bit, a 12-bit test register, a 4-bit module-control register and a system-configuration register. A test mode (module control bit 3) combined with a force bit (test register bit 11) sets every implemented status bit and freezes acknowledgement. Writing the system-configuration register with bit 1 set returns every register of the block to its reset value in a single cycle. All registers are reached through a simple 32-bit register port that rejects accesses of any other width. Read data is combinational.

Top module: `spi_irq_hub`

## Requirements
- R1: A status bit is sticky and is set on every clock edge where its event input is high. Channel n uses bit 4n for transmit empty, bit 4n+1 for transmit underrun and bit 4n+2 for receive full. Receive overrun uses bit 3 and wakeup uses bit 16. The status register is at address 0x0C. An event that is high in the same cycle as a clear of its bit leaves the bit set.
- R2: The output `irq` is a register. Its value at each clock edge is the OR of (status AND enable) as those registers stood before that edge, so it follows a status or enable change by one cycle.
- R3: The enable register at address 0x10 stores the written data ANDed with 0x1777F and reads back that value.
- R4: A 32-bit write to the status register (0x0C) clears every status bit that is written as 1 and leaves bits written as 0 unchanged.
- R5: A write to the status register has no effect while module control bit 3 and test register bit 11 are both 1.
- R6: Two writes set every status bit in 0x1777F. The first is a write to the test register (0x18) with bit 11 set while module control bit 3 is already 1. The second is a write to module control (0x1C) with bit 3 set while test bit 11 is already 1. A write of test bit 11 while module control bit 3 is 0 leaves the status unchanged.
- R7: After reset, status, enable, wakeup (0x14) and test read 0, and module control reads 4. The test register keeps write bits 11:0, module control keeps bits 3:0 and wakeup keeps bit 0.
- R8: A write to system configuration (0x04) with bit 1 set resets status, enable, wakeup, test and module control to their reset values. System configuration keeps the written data ANDed with 0x31D, whether or not the write caused a reset.
- R9: Address 0x00 reads 0x91 and address 0x08 reads 1. Writes to these two addresses change nothing and raise no error.
- R10: An access with `reg_size` other than 2 (4 bytes) raises `reg_err`, changes no register and returns read data 0. An access to an address outside 0x00-0x1C, or one that is not word aligned, also raises `reg_err` and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_size | input | 2 | Access size code (0:1 byte, 1:2 bytes, 2:4 bytes) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading |
| reg_err | output | 1 | Access rejected (bad size or address) |
| ev_tx_empty | input | NUM_CH | Per-channel transmit-empty events |
| ev_tx_underrun | input | NUM_CH | Per-channel transmit-underrun events |
| ev_rx_full | input | NUM_CH | Per-channel receive-full events |
| ev_rx_overrun | input | 1 | Receive-overrun event (channel 0) |
| ev_wakeup | input | 1 | Wakeup event |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can act on the status register in the same cycle. In the first, an event sets a bit while a status write clears it. The bench holds a receive-full event high during the very cycle of an all-ones acknowledge and expects that bit alone to survive. In the second, acknowledgement meets the force condition: the bench enters the force state, writes all ones to the status register, and expects every implemented bit to still be set. The bench then drops the force bit and expects the same write to clear the status.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int DATA_W = 32;
  localparam int STRIDE = 4;
  localparam int OFF_TXE = 0;
  localparam int OFF_TXU = 1;
  localparam int OFF_RXF = 2;
  localparam int OFF_RXO = 3;

  localparam int A_ID      = 'h00;
  localparam int A_SYSCFG  = 'h04;
  localparam int A_SYSSTAT = 'h08;
  localparam int A_STAT    = 'h0C;
  localparam int A_EN      = 'h10;
  localparam int A_WAKE    = 'h14;
  localparam int A_TEST    = 'h18;
  localparam int A_MODCTL  = 'h1C;

  localparam logic [DATA_W-1:0] ID_VALUE    = 32'h91;
  localparam logic [DATA_W-1:0] SYSCFG_KEEP = 32'h31D;
  localparam logic [3:0]        MODCTL_RST  = 4'h4;
  localparam int SRST_BIT   = 1;
  localparam int TMODE_BIT  = 3;
  localparam int TFORCE_BIT = 11;
  localparam int SIZE_WORD  = 2;

  // Implemented status bits for a given channel count.
  function automatic logic [DATA_W-1:0] impl_mask(input int nch);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < nch; c++) begin
      m[STRIDE*c + OFF_TXE] = 1'b1;
      m[STRIDE*c + OFF_TXU] = 1'b1;
      m[STRIDE*c + OFF_RXF] = 1'b1;
    end
    m[OFF_RXO]      = 1'b1;
    m[STRIDE * nch] = 1'b1;
    return m;
  endfunction

  // Next status value: clear, then set (set wins), then force.
  function automatic logic [DATA_W-1:0] next_status(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] clr,
      input logic [DATA_W-1:0] set,
      input logic              force_all,
      input logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] v;
    v = (cur & ~clr) | (set & mask);
    if (force_all) v = v | mask;
    return v;
  endfunction

  function automatic logic pending(input logic [DATA_W-1:0] st,
                                   input logic [DATA_W-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q,
  output logic              wake_q,
  output logic [11:0]       test_q,
  output logic [3:0]        modctl_q,
  output logic [DATA_W-1:0] syscfg_q,
  output logic              soft_rst,
  output logic              clr_block,
  output logic              clr_strobe,
  output logic              force_fire
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_CH);

  logic hit_cfg, hit_stat, hit_test, hit_mod;
  assign hit_cfg  = wr_ok && (addr == ADDR_W'(A_SYSCFG));
  assign hit_stat = wr_ok && (addr == ADDR_W'(A_STAT));
  assign hit_test = wr_ok && (addr == ADDR_W'(A_TEST));
  assign hit_mod  = wr_ok && (addr == ADDR_W'(A_MODCTL));

  assign soft_rst   = hit_cfg && wdata[SRST_BIT];
  assign clr_block  = modctl_q[TMODE_BIT] && test_q[TFORCE_BIT];
  assign clr_strobe = hit_stat && !clr_block;
  assign force_fire = (hit_test && modctl_q[TMODE_BIT] && wdata[TFORCE_BIT]) ||
                      (hit_mod  && wdata[TMODE_BIT] && test_q[TFORCE_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      wake_q   <= 1'b0;
      test_q   <= '0;
      modctl_q <= MODCTL_RST;
      syscfg_q <= '0;
    end else if (soft_rst) begin
      en_q     <= '0;
      wake_q   <= 1'b0;
      test_q   <= '0;
      modctl_q <= MODCTL_RST;
      syscfg_q <= wdata & SYSCFG_KEEP;
    end else if (wr_ok) begin
      case (addr)
        ADDR_W'(A_SYSCFG): syscfg_q <= wdata & SYSCFG_KEEP;
        ADDR_W'(A_EN):     en_q     <= wdata & MASK;
        ADDR_W'(A_WAKE):   wake_q   <= wdata[0];
        ADDR_W'(A_TEST):   test_q   <= wdata[11:0];
        ADDR_W'(A_MODCTL): modctl_q <= wdata[3:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              clr_strobe,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic              force_fire,
  input  logic [NUM_CH-1:0] ev_txe,
  input  logic [NUM_CH-1:0] ev_txu,
  input  logic [NUM_CH-1:0] ev_rxf,
  input  logic              ev_rxo,
  input  logic              ev_wake,
  output logic [DATA_W-1:0] stat_q
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_CH);

  logic [DATA_W-1:0] ev_vec;
  logic [DATA_W-1:0] clr_vec;

  always_comb begin
    ev_vec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ev_vec[STRIDE*c + OFF_TXE] = ev_txe[c];
      ev_vec[STRIDE*c + OFF_TXU] = ev_txu[c];
      ev_vec[STRIDE*c + OFF_RXF] = ev_rxf[c];
    end
    ev_vec[OFF_RXO]         = ev_rxo;
    ev_vec[STRIDE * NUM_CH] = ev_wake;
  end

  assign clr_vec = clr_strobe ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_q <= '0;
    else if (soft_rst) stat_q <= '0;
    else               stat_q <= next_status(stat_q, clr_vec, ev_vec, force_fire, MASK);
  end
endmodule

// File: rtl/spi_irq_drive.sv
module spi_irq_drive
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] en,
  output logic              irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending(stat, en);
  end
endmodule

// File: rtl/spi_irq_hub.sv
module spi_irq_hub
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic [NUM_CH-1:0] ev_tx_empty,
  input  logic [NUM_CH-1:0] ev_tx_underrun,
  input  logic [NUM_CH-1:0] ev_rx_full,
  input  logic              ev_rx_overrun,
  input  logic              ev_wakeup,
  output logic              irq
);
  logic [DATA_W-1:0] en_q, syscfg_q, stat_q, rd_mux;
  logic              wake_q;
  logic [11:0]       test_q;
  logic [3:0]        modctl_q;
  logic              soft_rst, clr_block, clr_strobe, force_fire;
  logic              mapped, size_ok, wr_ok;

  always_comb begin
    mapped = 1'b1;
    case (reg_addr)
      ADDR_W'(A_ID):      rd_mux = ID_VALUE;
      ADDR_W'(A_SYSCFG):  rd_mux = syscfg_q;
      ADDR_W'(A_SYSSTAT): rd_mux = 32'd1;
      ADDR_W'(A_STAT):    rd_mux = stat_q;
      ADDR_W'(A_EN):      rd_mux = en_q;
      ADDR_W'(A_WAKE):    rd_mux = {31'd0, wake_q};
      ADDR_W'(A_TEST):    rd_mux = {20'd0, test_q};
      ADDR_W'(A_MODCTL):  rd_mux = {28'd0, modctl_q};
      default: begin
        rd_mux = '0;
        mapped = 1'b0;
      end
    endcase
  end

  assign size_ok   = (reg_size == 2'(SIZE_WORD));
  assign wr_ok     = reg_wr && size_ok && mapped;
  assign reg_err   = (reg_wr || reg_rd) && !(size_ok && mapped);
  assign reg_rdata = (reg_rd && size_ok) ? rd_mux : '0;

  spi_irq_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .wake_q(wake_q), .test_q(test_q), .modctl_q(modctl_q),
    .syscfg_q(syscfg_q), .soft_rst(soft_rst), .clr_block(clr_block),
    .clr_strobe(clr_strobe), .force_fire(force_fire)
  );

  spi_irq_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr_strobe(clr_strobe),
    .clr_bits(reg_wdata), .force_fire(force_fire),
    .ev_txe(ev_tx_empty), .ev_txu(ev_tx_underrun), .ev_rxf(ev_rx_full),
    .ev_rxo(ev_rx_overrun), .ev_wake(ev_wakeup), .stat_q(stat_q)
  );

  spi_irq_drive u_drv (
    .clk(clk), .rst_n(rst_n), .stat(stat_q), .en(en_q), .irq_q(irq)
  );
endmodule

// File: rtl/spi_irq_hub_chk.sv
module spi_irq_hub_chk
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ok,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NUM_CH-1:0] ev_tx_empty,
  input logic [31:0]       stat_q,
  input logic [31:0]       en_q,
  input logic [11:0]       test_q,
  input logic [3:0]        modctl_q,
  input logic              irq,
  input logic              soft_rst,
  input logic              force_fire,
  input logic              clr_block
);
  localparam logic [31:0] MASK = impl_mask(NUM_CH);

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_empty[0] && !soft_rst) |=> stat_q[0]); // R1

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat_q & en_q)))); // R2

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && reg_addr == ADDR_W'(A_EN)) |=> (en_q == ($past(reg_wdata) & MASK))); // R3

  AST_CLR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && reg_addr == ADDR_W'(A_STAT) && clr_block)
      |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5

  AST_FORCE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    force_fire |=> ((stat_q & MASK) == MASK)); // R6

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_q == '0 && en_q == '0 && test_q == '0 && modctl_q == MODCTL_RST)); // R8
endmodule

bind spi_irq_hub spi_irq_hub_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ev_tx_empty(ev_tx_empty), .stat_q(stat_q), .en_q(en_q), .test_q(test_q),
  .modctl_q(modctl_q), .irq(irq), .soft_rst(soft_rst), .force_fire(force_fire),
  .clr_block(clr_block)
);

// File: tb/sim_spi_irq_hub.sv
`timescale 1ns/1ps
module sim_spi_irq_hub;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [1:0] reg_size = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_err;
  logic [NCH-1:0] ev_txe = '0, ev_txu = '0, ev_rxf = '0;
  logic ev_rxo = 1'b0, ev_wk = 1'b0;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] rv;
  logic last_err;
  logic [31:0] exp_mask;

  always #2 clk = ~clk;

  spi_irq_hub #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .ev_tx_empty(ev_txe), .ev_tx_underrun(ev_txu), .ev_rx_full(ev_rxf),
    .ev_rx_overrun(ev_rxo), .ev_wakeup(ev_wk), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d; reg_size = sz;
    #1 last_err = reg_err;
    @(negedge clk);
    reg_wr = 1'b0; reg_size = 2'd2;
  endtask

  task automatic rd(input int a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a); reg_size = sz;
    #1 d = reg_rdata; last_err = reg_err;
    reg_rd = 1'b0; reg_size = 2'd2;
  endtask

  task automatic drive_bit(input int b, input logic v);
    if (b == 4*NCH)  ev_wk = v;
    else if (b == 3) ev_rxo = v;
    else if (b % 4 == 0) ev_txe[b/4] = v;
    else if (b % 4 == 1) ev_txu[b/4] = v;
    else                 ev_rxf[b/4] = v;
  endtask

  task automatic pulse_bit(input int b);
    @(negedge clk); drive_bit(b, 1'b1);
    @(negedge clk); drive_bit(b, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_mask = 32'd1 << (4*NCH);
    for (int c = 0; c < NCH; c++) exp_mask |= (32'd7 << (4*c));
    exp_mask |= 32'd8;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset values, R9 constants
    rd('h0C, rv); chk("R7 status reset", rv, 0);
    rd('h10, rv); chk("R7 enable reset", rv, 0);
    rd('h14, rv); chk("R7 wakeup reset", rv, 0);
    rd('h18, rv); chk("R7 test reset", rv, 0);
    rd('h1C, rv); chk("R7 modctl reset", rv, 4);
    chk("R2 irq reset", {31'd0, irq}, 0);
    rd('h00, rv); chk("R9 id", rv, 32'h91);
    rd('h08, rv); chk("R9 sysstat", rv, 1);

    // R1/R4 sweep every implemented event bit
    for (int b = 0; b <= 4*NCH; b++) begin
      if (exp_mask[b]) begin
        pulse_bit(b);
        rd('h0C, rv); chk($sformatf("R1 event bit %0d", b), rv, 32'd1 << b);
        wr('h0C, ~(32'd1 << b));
        rd('h0C, rv); chk($sformatf("R4 zero-written bit %0d kept", b), rv, 32'd1 << b);
        wr('h0C, 32'd1 << b);
        rd('h0C, rv); chk($sformatf("R4 clear bit %0d", b), rv, 0);
      end
    end

    // R3 enable masking
    wr('h10, 32'hFFFF_FFFF); rd('h10, rv); chk("R3 enable all ones", rv, exp_mask);
    wr('h10, 32'hA5A5_A5A5); rd('h10, rv); chk("R3 enable pattern", rv, 32'hA5A5_A5A5 & exp_mask);

    // R2 irq timing per bit
    for (int b = 0; b <= 4*NCH; b++) begin
      if (exp_mask[b]) begin
        int o;
        o = (b == 0) ? 1 : 0;
        wr('h10, 32'd1 << b);
        pulse_bit(o);
        @(negedge clk); chk($sformatf("R2 masked bit %0d irq low", o), {31'd0, irq}, 0);
        wr('h0C, 32'hFFFF_FFFF);
        pulse_bit(b);
        chk($sformatf("R2 irq lags bit %0d", b), {31'd0, irq}, 0);
        @(negedge clk); chk($sformatf("R2 irq bit %0d", b), {31'd0, irq}, 1);
        wr('h0C, 32'd1 << b);
        chk($sformatf("R2 irq held after clear %0d", b), {31'd0, irq}, 1);
        @(negedge clk); chk($sformatf("R2 irq drops %0d", b), {31'd0, irq}, 0);
      end
    end
    wr('h10, 0);

    // R1 set wins over clear in the same cycle
    @(negedge clk);
    ev_rxf[1] = 1'b1; reg_wr = 1'b1; reg_addr = AW'('h0C); reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    ev_rxf[1] = 1'b0; reg_wr = 1'b0;
    rd('h0C, rv); chk("R1 set beats clear", rv, 32'd1 << 6);
    wr('h0C, 32'hFFFF_FFFF);

    // R7 field widths
    wr('h18, 32'hFFFF_F7FF); rd('h18, rv); chk("R7 test width", rv, 32'h7FF);
    wr('h1C, 32'hFFFF_FFF7); rd('h1C, rv); chk("R7 modctl width", rv, 32'h7);
    wr('h14, 32'hFFFF_FFFF); rd('h14, rv); chk("R7 wakeup width", rv, 1);
    wr('h1C, 0); wr('h18, 0); wr('h14, 0);

    // R6 force, R5 frozen clear
    wr('h18, 32'h800); rd('h0C, rv); chk("R6 no force without test mode", rv, 0);
    wr('h1C, 32'h8);   rd('h0C, rv); chk("R6 force via modctl", rv, exp_mask);
    wr('h0C, 32'hFFFF_FFFF); rd('h0C, rv); chk("R5 clear ignored", rv, exp_mask);
    wr('h18, 0); wr('h0C, 32'hFFFF_FFFF); rd('h0C, rv); chk("R4 clear after force off", rv, 0);
    wr('h18, 32'h800); rd('h0C, rv); chk("R6 force via test", rv, exp_mask);
    wr('h1C, 0); wr('h18, 0); wr('h0C, 32'hFFFF_FFFF);

    // R8 soft reset
    wr('h10, 32'h5); wr('h14, 1); wr('h18, 32'h123); wr('h1C, 32'h3);
    pulse_bit(2);
    wr('h04, 32'hFFFF_FFFF);
    rd('h04, rv); chk("R8 syscfg kept bits", rv, 32'h31D);
    rd('h0C, rv); chk("R8 status cleared", rv, 0);
    rd('h10, rv); chk("R8 enable cleared", rv, 0);
    rd('h14, rv); chk("R8 wakeup cleared", rv, 0);
    rd('h18, rv); chk("R8 test cleared", rv, 0);
    rd('h1C, rv); chk("R8 modctl restored", rv, 4);
    wr('h10, 32'h5); wr('h04, 32'h5);
    rd('h04, rv); chk("R8 syscfg plain write", rv, 32'h5);
    rd('h10, rv); chk("R8 no reset without bit1", rv, 32'h5);

    // R9 read-only writes
    wr('h00, 32'hFFFF_FFFF); chk("R9 id write no error", {31'd0, last_err}, 0);
    wr('h08, 32'h0);
    rd('h00, rv); chk("R9 id unchanged", rv, 32'h91);
    rd('h08, rv); chk("R9 sysstat unchanged", rv, 1);

    // R10 bad size / address
    wr('h10, 32'h70, 2'd1); chk("R10 narrow write error", {31'd0, last_err}, 1);
    rd('h10, rv); chk("R10 narrow write no effect", rv, 32'h5);
    rd('h10, rv, 2'd0); chk("R10 narrow read data", rv, 0);
    chk("R10 narrow read error", {31'd0, last_err}, 1);
    rd('h20, rv); chk("R10 unmapped read data", rv, 0);
    chk("R10 unmapped error", {31'd0, last_err}, 1);
    rd('h11, rv); chk("R10 unaligned error", {31'd0, last_err}, 1);
    rd('h10, rv); chk("R10 good access no error", {31'd0, last_err}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule